// File: doc/BRIEF.md
# Dual Prescaled Interval Timer

Two independent interval timers sit behind a small byte-wide write window. Each timer owns a prescaler register and a divider register, both 16 bits wide. The prescaler stage counts system clocks. Each time it runs out, the divider stage counts down by one. When the divider has also run out, the timer emits a one-clock interrupt pulse and both stages start again from their programmed values. The current contents of every prescaler and divider counter are visible on readback ports, so software or a neighbouring block can sample the progress of a timer at any moment.

Any single byte written to a timer's prescaler or divider restarts that timer at once, with the register value as it stands after that byte. Programming a full 16-bit value therefore takes two writes, and only the later of the two sets the moment counting begins. Each timer is a two-state machine. `TMR_IDLE` is the state after reset, with no counting and no interrupt. `TMR_RUN` counts. The transition *arm* (IDLE to RUN) happens on the first write to the timer. The transition *restart* (RUN to RUN) happens on any later write, and reloads both counters. The transition *tick* (RUN to RUN) is the ordinary clock-by-clock count, including the reload that follows each interrupt.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register and counter is zero, both timers are in TMR_IDLE, and no interrupt is raised until that timer is written.
- R2: The write offset is decoded as follows. Bit 2 selects the timer (0 or 1). Bit 1 selects the register (0 = prescaler, 1 = divider). Bit 0 selects the byte (0 = high byte, 1 = low byte). Offsets 0 to 3 belong to timer 0 and offsets 4 to 7 belong to timer 1.
- R3: A byte write changes only the addressed byte of the addressed register. The other byte keeps its value.
- R4: A write restarts only the addressed timer. On the next clock its prescaler counter holds the new prescaler value P and its divider counter holds the new divider value D. No interrupt is raised in that cycle. The other timer is unaffected.
- R5: While running, the prescaler counter decreases by one each clock. When it reaches zero, it expires and is reloaded with P on the following clock, so it expires once every P+1 clocks.
- R6: Each prescaler expiry with a nonzero divider counter decreases the divider counter by one. The first interrupt becomes visible (P+1)*(D+1) clocks after the restarting write.
- R7: The interrupt is a one-clock pulse. In the same clock, both counters read back as P and D again, and further pulses follow every (P+1)*(D+1) clocks.
- R8: With P = 0 and D = 0, the interrupt is asserted on every clock.
- R9: The readback ports show each timer's live prescaler and divider counts. Timer n occupies bits [16n+15:16n] of each port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Byte write strobe |
| wr_ofs | input | 3 | Byte offset within the register window |
| wr_data | input | 8 | Byte to write |
| irq | output | 2 | Interrupt pulse per timer |
| presc_now | output | 32 | Live prescaler counts, timer n in bits [16n+15:16n] |
| div_now | output | 32 | Live divider counts, timer n in bits [16n+15:16n] |

## Verification
The main counting function is tried with a table of prescaler and divider pairs. These include both values zero, only one value nonzero, both values nonzero, and a prescaler whose only set bit lies in the high byte. Together they show whether the two stages multiply rather than add, whether an off-by-one exists in either stage, and whether the high byte lane is used. The table alternates between the two timers, and the timer not being programmed keeps running, which exposes crosstalk between them. Directed tests then write the same byte again partway through a period, to show that the count really restarts. They also write to the other timer partway through a period, to show that such a write does not restart this one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/tmr_wr_decode.sv
module tmr_wr_decode #(
    parameter int NUM_TMR = 2,
    parameter int LANE_W  = 1,
    parameter int OFS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [OFS_W-1:0]  wr_ofs,
    output logic [NUM_TMR-1:0] hit,
    output logic              sel_div,
    output logic [LANE_W-1:0] lane
);
    localparam int TMR_W = OFS_W - LANE_W - 1;

    logic [TMR_W-1:0] tsel;

    assign tsel    = wr_ofs[OFS_W-1 -: TMR_W];
    assign sel_div = wr_ofs[LANE_W];
    assign lane    = wr_ofs[LANE_W-1:0];

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_hit
        assign hit[t] = wr_stb && (tsel == TMR_W'(t));
    end

    // R2: a strobe addresses exactly one timer, no strobe addresses none
    assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $countones(hit) == 1);
    assert_no_stray_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> hit == '0);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LANE_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_div,
    input  logic [LANE_W-1:0] ld_lane,
    input  logic [7:0]        ld_byte,
    output logic              irq,
    output logic [CNT_W-1:0]  pcnt_o,
    output logic [CNT_W-1:0]  dcnt_o
);
    localparam int BYTES = CNT_W / 8;

    tmr_state_e       state_q, state_n;
    logic [CNT_W-1:0] pre_q, div_q, pre_n, div_n;
    logic [CNT_W-1:0] pcnt_q, dcnt_q;
    logic             irq_q;
    logic             p_exp, fire;

    // merge the written byte into the addressed register (lane 0 = most significant)
    always_comb begin
        pre_n = pre_q;
        div_n = div_q;
        if (ld_en) begin
            for (int k = 0; k < BYTES; k++) begin
                if (ld_lane == LANE_W'(k)) begin
                    if (ld_div) div_n[(BYTES-1-k)*8 +: 8] = ld_byte;
                    else        pre_n[(BYTES-1-k)*8 +: 8] = ld_byte;
                end
            end
        end
    end

    assign p_exp = (state_q == TMR_RUN) && (pcnt_q == '0);
    assign fire  = p_exp && (dcnt_q == '0);

    // next-state logic: arm, restart, tick
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            TMR_IDLE: if (ld_en) state_n = TMR_RUN;
            TMR_RUN:  state_n = TMR_RUN;
            default:  state_n = TMR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_n;
    end

    // registers, counters and interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            div_q  <= '0;
            pcnt_q <= '0;
            dcnt_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pre_q <= pre_n;
            div_q <= div_n;
            if (ld_en) begin
                pcnt_q <= pre_n;
                dcnt_q <= div_n;
                irq_q  <= 1'b0;
            end else begin
                unique case (state_q)
                    TMR_IDLE: irq_q <= 1'b0;
                    TMR_RUN: begin
                        irq_q <= fire;
                        if (!p_exp) begin
                            pcnt_q <= pcnt_q - 1'b1;
                        end else if (dcnt_q != '0) begin
                            dcnt_q <= dcnt_q - 1'b1;
                            pcnt_q <= pre_q;
                        end else begin
                            pcnt_q <= pre_q;
                            dcnt_q <= div_q;
                        end
                    end
                    default: irq_q <= 1'b0;
                endcase
            end
        end
    end

    assign irq    = irq_q;
    assign pcnt_o = pcnt_q;
    assign dcnt_o = dcnt_q;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_IDLE) |-> !irq_q);
    assert_restart_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (state_q == TMR_RUN) && !irq_q && pcnt_q == $past(pre_n) && dcnt_q == $past(div_n));
    assert_presc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN && !ld_en && pcnt_q != '0) |=> pcnt_q == $past(pcnt_q) - 1'b1);
    assert_div_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (p_exp && !ld_en && dcnt_q != '0) |=> dcnt_q == $past(dcnt_q) - 1'b1 && pcnt_q == pre_q);
    assert_pulse_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> pcnt_q == pre_q && dcnt_q == div_q);
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && (pre_q != '0 || div_q != '0)) |=> !irq_q);
    assert_every_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && pre_q == '0 && div_q == '0 && !ld_en) |=> irq_q);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
    parameter int NUM_TMR = 2,
    parameter int CNT_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_stb,
    input  logic [2:0]                 wr_ofs,
    input  logic [7:0]                 wr_data,
    output logic [NUM_TMR-1:0]         irq,
    output logic [NUM_TMR*CNT_W-1:0]   presc_now,
    output logic [NUM_TMR*CNT_W-1:0]   div_now
);
    localparam int BYTES  = CNT_W / 8;
    localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int OFS_W  = 3;

    logic [NUM_TMR-1:0] hit;
    logic               sel_div;
    logic [LANE_W-1:0]  lane;

    tmr_wr_decode #(
        .NUM_TMR (NUM_TMR),
        .LANE_W  (LANE_W),
        .OFS_W   (OFS_W)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_ofs  (wr_ofs),
        .hit     (hit),
        .sel_div (sel_div),
        .lane    (lane)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        tmr_chan #(
            .CNT_W  (CNT_W),
            .LANE_W (LANE_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_en   (hit[t]),
            .ld_div  (sel_div),
            .ld_lane (lane),
            .ld_byte (wr_data),
            .irq     (irq[t]),
            .pcnt_o  (presc_now[t*CNT_W +: CNT_W]),
            .dcnt_o  (div_now[t*CNT_W +: CNT_W])
        );
    end
endmodule

// File: tb/dual_interval_timer_test.sv
module dual_interval_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [2:0]  wr_ofs = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  irq;
    logic [31:0] presc_now, div_now;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_ofs(wr_ofs),
        .wr_data(wr_data), .irq(irq), .presc_now(presc_now), .div_now(div_now)
    );

    // {timer, prescaler, divider}
    localparam logic [32:0] VEC [6] = '{
        {1'b0, 16'd0,     16'd0},
        {1'b1, 16'd1,     16'd0},
        {1'b0, 16'd0,     16'd3},
        {1'b1, 16'd2,     16'd2},
        {1'b0, 16'h0100,  16'd0},
        {1'b1, 16'd3,     16'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] ofs, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_ofs = ofs; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic program_tmr(input int t, input logic [15:0] p, input logic [15:0] d);
        wr(3'(t*4+0), p[15:8]);
        wr(3'(t*4+1), p[7:0]);
        wr(3'(t*4+2), d[15:8]);
        wr(3'(t*4+3), d[7:0]);
    endtask

    // count negedges until irq[t] is seen high
    task automatic wait_irq(input int t, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq[t] && n < 100000);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        logic [15:0] hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 prescaler counts after reset", presc_now, 32'h0);
        check("R1 divider counts after reset", div_now, 32'h0);
        repeat (20) @(negedge clk);
        check("R1 idle stays quiet", 32'(irq), 32'h0);

        // R3 byte lanes, R9 readback
        wr(3'd0, 8'hAB);
        check("R3 high byte write", 32'(presc_now[15:0]), 32'hAB00);
        wr(3'd1, 8'hCD);
        check("R3 low byte keeps high", 32'(presc_now[15:0]), 32'hABCD);
        wr(3'd0, 8'h00);
        check("R3 high byte keeps low", 32'(presc_now[15:0]), 32'h00CD);
        @(negedge clk);
        check("R9 live prescaler count", 32'(presc_now[15:0]), 32'h00CC);
        // R2 offset 6 = timer 1 divider high byte
        hold = div_now[15:0];
        wr(3'd6, 8'h12);
        check("R2 timer1 divider high", 32'(div_now[31:16]), 32'h1200);
        check("R2 timer0 divider untouched", 32'(div_now[15:0]), 32'(hold));
        check("R2 timer1 prescaler untouched", 32'(presc_now[31:16]), 32'h0);

        // table walk: R5 R6 R7
        foreach (VEC[i]) begin
            int t;
            logic [15:0] p, d;
            int e;
            t = int'(VEC[i][32]);
            p = VEC[i][31:16];
            d = VEC[i][15:0];
            e = (int'(p) + 1) * (int'(d) + 1);
            program_tmr(t, p, d);
            check("R4 restart loads prescaler", 32'(presc_now[t*16 +: 16]), 32'(p));
            wait_irq(t, n);
            check("R6 first interrupt delay", n, e);
            check("R7 reload at pulse", {presc_now[t*16 +: 16], div_now[t*16 +: 16]}, {p, d});
            wait_irq(t, n);
            check("R7 repeat period", n, e);
        end

        // R4 restart by rewriting same byte mid-period
        program_tmr(0, 16'd9, 16'd0);
        repeat (3) @(negedge clk);
        check("R5 prescaler decrement", 32'(presc_now[15:0]), 32'd6);
        repeat (2) @(negedge clk);
        wr(3'd1, 8'd9);
        wait_irq(0, n);
        check("R4 restart delays interrupt", n, 10);

        // R4 write to other timer does not restart this one
        program_tmr(0, 16'd19, 16'd0);
        repeat (5) @(negedge clk);
        wr(3'd5, 8'h07);
        wait_irq(0, n);
        check("R4 other timer write no restart", n, 13);

        // R8 zero settings -> every clock
        program_tmr(1, 16'd0, 16'd0);
        n = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (irq[1]) n++;
        end
        check("R8 interrupt every clock", n, 6);

        finish_run();
    end
endmodule